// File: doc/BRIEF.md
# Asynchronous Static RAM Bridge

The bridge takes single-word read and write requests from a clocked host and turns each one into a correctly timed access on an external asynchronous static RAM. The RAM holds 64K words of 16 bits and is controlled by active-low chip-select, write-strobe, output-gate and one byte-select per 8-bit lane. Every phase of an access (write turnaround, write drive, read access, recovery) lasts a whole number of clocks. These counts are derived when the design is elaborated from the clock period and the speed-grade limits in nanoseconds. The result is that a change of clock or RAM grade only needs new parameter values.

The host side is a valid/ready request channel plus a response pulse. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the whole access, recovery included, has finished, so only one access is ever in flight. A request presented while `req_ready` is low is ignored and must be held by the host. The read response cannot be stalled: `rsp_valid` is high for exactly one clock with the data. On the memory side the data bus is split into output, output-enable and input so that an external tristate buffer can be used. The bridge keeps its drivers off until the RAM is guaranteed to have released the bus.

Top module: `sram_bridge`

## Requirements
- R1: After a synchronous active-high reset, all RAM controls (`mem_ce_n`, `mem_we_n`, `mem_oe_n`, every `mem_be_n` bit) are 1, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A request is taken only on an edge with `req_valid` and `req_ready` both high. `req_ready` is low for every clock from that edge until the access and its recovery are finished. With the default parameters this is 9 clocks for a write and 10 for a read.
- R3: A write holds `mem_we_n` and `mem_ce_n` low for at least the larger of ceil(write-pulse/period) and ceil(address-to-end/period) clocks. With the defaults this is at least 6 clocks.
- R4: During a write, `mem_oe_n` stays 1. `mem_dq_oe` rises only after `mem_we_n` has been low for ceil(release-time/period) clocks, which is 4 with the defaults.
- R5: Write data is driven unchanged for at least ceil(data-setup/period) clocks (4 with the defaults) before the edge that ends the write. `mem_dq_oe` is 0 from that edge on.
- R6: Mask bit 0 selects bits 7:0 through `mem_be_n[0]`, and mask bit 1 selects bits 15:8 through `mem_be_n[1]` (0 = selected). A write changes only the selected lanes. A mask of 2'b00 changes nothing.
- R7: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high for ceil(max(address, select, output-gate access)/period) clocks (7 with the defaults). The bus is sampled on the last of these clocks, and `rsp_valid` is high for exactly the following clock.
- R8: In `rsp_data`, a lane whose mask bit is 0 reads as zero, whatever the bus carried.
- R9: Whenever `req_ready` is high, the RAM is deselected: every control pin is 1 and `mem_dq_oe` is 0.
- R10: `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R11: A request raised while `req_ready` is low has no effect: the access in progress and the RAM contents are unchanged.
- R12: After a read access ends, the bus stays idle for ceil(output-release/period) clocks (3 with the defaults) before `req_ready` rises.
- R13: A reset in the middle of an access returns the block to the R1 state at once, and no response is produced for the aborted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = low byte |
| rsp_valid | output | 1 | One-clock read data strobe |
| rsp_data | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 16 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output gate, active low |
| mem_be_n | output | 2 | RAM byte selects, bit 0 = low lane, active low |
| mem_dq_out | output | 16 | Data to tristate buffer |
| mem_dq_oe | output | 1 | Tristate buffer enable |
| mem_dq_in | input | 16 | Data from RAM bus |

## Verification
A wrong phase count in the bridge shows up directly at the pins. A shortened read access makes the bench RAM return its not-yet-valid pattern, and a wrong response appears within one access. A premature driver enable or a late driver release appears at the first write, as a turnaround or drive-after-end violation on the pins. A lost or wrong lane select appears as wrong data on the next read-back of that word. A broken busy window appears as a wrong ready-low count, or as a request taken mid-access that corrupts a word checked a few accesses later.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WTURN,
    ST_WDRV,
    ST_RACC,
    ST_RECOV
  } phase_e;

  // whole clocks covering a nanosecond limit, never less than one
  function automatic int ns2cyc(input int ns, input int per);
    int c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             close,
  input  logic             capture,
  input  logic [DW-1:0]    wdata_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [DW-1:0]    dq_in,
  output logic [DW-1:0]    dq_out,
  output logic [DW-1:0]    rdata,
  output logic [LANES-1:0] sel_n
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] wreg;
    logic [LANE_W-1:0] rreg;
    logic              seln;

    always_ff @(posedge clk) begin
      if (rst) begin
        wreg <= '0;
        rreg <= '0;
        seln <= 1'b1;
      end else begin
        if (take) begin
          wreg <= wdata_i[g*LANE_W +: LANE_W];
          seln <= ~mask_i[g];
        end else if (close) begin
          seln <= 1'b1;
        end
        if (capture)
          rreg <= seln ? '0 : dq_in[g*LANE_W +: LANE_W];
      end
    end

    assign dq_out[g*LANE_W +: LANE_W] = wreg;
    assign rdata[g*LANE_W +: LANE_W]  = rreg;
    assign sel_n[g]                   = seln;
  end
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
  import sram_bridge_pkg::*;
#(
  parameter int CLK_NS    = 8,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_ACE_NS  = 55,
  parameter int T_DOE_NS  = 25,
  parameter int T_HZOE_NS = 20,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 40,
  parameter int T_AW_NS   = 45,
  parameter int T_SD_NS   = 25,
  parameter int T_HZWE_NS = 25,
  parameter int ADDR_W    = 16,
  parameter int LANE_W    = 8,
  parameter int LANES     = 2,
  localparam int DW       = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [LANES-1:0]  mem_be_n,
  output logic [DW-1:0]     mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DW-1:0]     mem_dq_in
);
  // phase lengths in clocks
  localparam int TURN = ns2cyc(T_HZWE_NS, CLK_NS);
  localparam int DRV  = imax(ns2cyc(T_SD_NS, CLK_NS),
                        imax(ns2cyc(T_AW_NS, CLK_NS) - TURN,
                             ns2cyc(T_PWE_NS, CLK_NS) - TURN));
  localparam int WREC = imax(1, ns2cyc(T_WC_NS, CLK_NS) - TURN - DRV);
  localparam int ACC  = imax(ns2cyc(T_AA_NS, CLK_NS),
                        imax(ns2cyc(T_ACE_NS, CLK_NS), ns2cyc(T_DOE_NS, CLK_NS)));
  localparam int RREC = imax(ns2cyc(T_HZOE_NS, CLK_NS), ns2cyc(T_RC_NS, CLK_NS) - ACC);
  localparam int MAXP = imax(imax(imax(TURN, DRV), imax(WREC, ACC)), RREC);
  localparam int CW   = $clog2(MAXP + 1);

  phase_e        st;
  logic          accept;
  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_exp;
  logic          lane_close;
  logic          lane_capture;

  assign req_ready    = (st == ST_IDLE);
  assign accept       = req_valid && req_ready;
  assign lane_close   = t_exp && ((st == ST_WDRV) || (st == ST_RACC));
  assign lane_capture = t_exp && (st == ST_RACC);

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    unique case (st)
      ST_IDLE: if (accept) begin
        t_load = 1'b1;
        t_val  = req_write ? CW'(TURN - 1) : CW'(ACC - 1);
      end
      ST_WTURN: if (t_exp) begin
        t_load = 1'b1;
        t_val  = CW'(DRV - 1);
      end
      ST_WDRV: if (t_exp) begin
        t_load = 1'b1;
        t_val  = CW'(WREC - 1);
      end
      ST_RACC: if (t_exp) begin
        t_load = 1'b1;
        t_val  = CW'(RREC - 1);
      end
      default: ;
    endcase
  end

  sram_phase_timer #(.W(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_exp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept) begin
          st       <= req_write ? ST_WTURN : ST_RACC;
          mem_ce_n <= 1'b0;
          mem_we_n <= ~req_write;
          mem_oe_n <= req_write;
          mem_addr <= req_addr;
        end
        ST_WTURN: if (t_exp) begin
          st        <= ST_WDRV;
          mem_dq_oe <= 1'b1;
        end
        ST_WDRV: if (t_exp) begin
          st        <= ST_RECOV;
          mem_ce_n  <= 1'b1;
          mem_we_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
        end
        ST_RACC: if (t_exp) begin
          st        <= ST_RECOV;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          rsp_valid <= 1'b1;
        end
        ST_RECOV: if (t_exp) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  sram_lane_path #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk     (clk),
    .rst     (rst),
    .take    (accept),
    .close   (lane_close),
    .capture (lane_capture),
    .wdata_i (req_wdata),
    .mask_i  (req_mask),
    .dq_in   (mem_dq_in),
    .dq_out  (mem_dq_out),
    .rdata   (rsp_data),
    .sel_n   (mem_be_n)
  );
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int CLK_NS    = 8,
  parameter int T_HZWE_NS = 25,
  parameter int LANES     = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_mask,
  input logic             rsp_valid,
  input logic             mem_ce_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic [LANES-1:0] mem_be_n,
  input logic             mem_dq_oe
);
  localparam int TURN = sram_bridge_pkg::ns2cyc(T_HZWE_NS, CLK_NS);

  logic [7:0] we_low;
  always_ff @(posedge clk) begin
    if (rst || mem_we_n)     we_low <= '0;
    else if (we_low != 8'hFF) we_low <= we_low + 8'd1;
  end

  a_r1_r9_idle_deselected: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe && (&mem_be_n)));

  a_r10_no_contention: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  a_r4_gate_high_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  a_r4_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (!mem_we_n && (int'(we_low) >= TURN)));

  a_r5_release_at_end: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !mem_dq_oe);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r6_lane_map: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_ce_n) |-> (mem_be_n == ~$past(req_mask)));

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind sram_bridge sram_bridge_chk #(
  .CLK_NS    (CLK_NS),
  .T_HZWE_NS (T_HZWE_NS),
  .LANES     (LANES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mask  (req_mask),
  .rsp_valid (rsp_valid),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_be_n  (mem_be_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_bridge.sv
`timescale 1ns/1ps
module sim_sram_bridge;
  localparam int PER     = 8;
  localparam int N_TURN  = 4;   // ceil(25/8)
  localparam int N_PULSE = 6;   // ceil(max(40,45)/8)
  localparam int N_SETUP = 4;   // ceil(25/8)
  localparam int N_ACC   = 7;   // ceil(55/8)
  localparam int WR_BUSY = 9;
  localparam int RD_BUSY = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [15:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_be_n;
  logic [15:0] mem_dq_out;
  logic [15:0] dq_in_r = 16'hA5A5;

  always #(PER/2) clk = ~clk;

  sram_bridge u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_in_r)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- RAM pin model ----------------
  logic [15:0] model_mem [int];
  logic [15:0] ref_mem   [int];
  logic [1:0]  prev_act = '0;
  logic [15:0] prev_dq = '0;
  logic [15:0] prev_addr = '0;
  logic        prev_oe = 1'b0;
  logic        prev_we_n = 1'b1;
  int          we_low_cnt = 0;
  int          drive_cnt = 0;
  int          rd_cnt = 0;
  bit          contention = 1'b0;

  function automatic logic [15:0] mget(input int a);
    return model_mem.exists(a) ? model_mem[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    logic [1:0]  act;
    logic [15:0] w;
    act[0] = !mem_ce_n && !mem_we_n && !mem_be_n[0];
    act[1] = !mem_ce_n && !mem_we_n && !mem_be_n[1];
    if (mem_dq_oe && !mem_ce_n && !mem_oe_n) contention = 1'b1;
    // R4: drivers come on only after the RAM has released the bus
    if (mem_dq_oe && !prev_oe)
      chk(!mem_we_n && we_low_cnt >= N_TURN, "R4", "strobe-low clocks before drive",
          we_low_cnt, N_TURN);
    if (|(prev_act & ~act)) begin
      w = mget(int'(prev_addr));
      if (prev_act[0] && !act[0]) w[7:0]  = prev_oe ? prev_dq[7:0]  : 8'hEE;
      if (prev_act[1] && !act[1]) w[15:8] = prev_oe ? prev_dq[15:8] : 8'hEE;
      model_mem[int'(prev_addr)] = w;
      chk(we_low_cnt >= N_PULSE, "R3", "write strobe clocks", we_low_cnt, N_PULSE);
      chk(drive_cnt >= N_SETUP, "R5", "data stable clocks", drive_cnt, N_SETUP);
      chk(!mem_dq_oe, "R5", "drivers off after write end", mem_dq_oe, 0);
    end
    if (mem_dq_oe && prev_oe && mem_dq_out == prev_dq) drive_cnt++;
    else if (mem_dq_oe) drive_cnt = 1;
    else drive_cnt = 0;
    we_low_cnt = mem_we_n ? 0 : we_low_cnt + 1;
    if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt++;
    else rd_cnt = 0;
    if (rd_cnt >= N_ACC) begin
      w = mget(int'(mem_addr));
      dq_in_r = {mem_be_n[1] ? 8'hFF : w[15:8], mem_be_n[0] ? 8'hFF : w[7:0]};
    end else begin
      dq_in_r = 16'hA5A5;
    end
    prev_act  = act;
    prev_dq   = mem_dq_out;
    prev_addr = mem_addr;
    prev_oe   = mem_dq_oe;
    prev_we_n = mem_we_n;
  end

  // ---------------- scoreboard ----------------
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        prev_rsp = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      prev_rsp = 1'b0;
    end else begin
      if (rsp_valid) begin
        chk(!prev_rsp, "R7", "response pulse width", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R13", "unexpected response", rsp_data, 0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rsp_data == e, t, "read data", rsp_data, e);
        end
      end
      prev_rsp = rsp_valid;
    end
  end

  // ---------------- driver ----------------
  task automatic idle_pins(input string req);
    chk(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe,
        req, "idle pins", {mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe}, 6'b111110);
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input logic [1:0] m, input string tag, input bit poke);
    int busy;
    logic [15:0] cur;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    idle_pins("R9");
    cur = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    if (wr) begin
      if (m[0]) cur[7:0]  = d[7:0];
      if (m[1]) cur[15:8] = d[15:8];
      ref_mem[int'(a)] = cur;
    end else begin
      exp_q.push_back({m[1] ? cur[15:8] : 8'h00, m[0] ? cur[7:0] : 8'h00});
      tag_q.push_back(tag);
    end
    req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    while (!req_ready) begin
      busy++;
      // R11: a write request raised mid-access must be ignored
      if (poke && busy == 3) begin
        req_write = 1'b1; req_addr = a ^ 16'h0001; req_wdata = 16'hDEAD;
        req_mask = 2'b11; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(busy == (wr ? WR_BUSY : RD_BUSY), wr ? "R2" : "R12", "busy clocks",
        busy, wr ? WR_BUSY : RD_BUSY);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready && !rsp_valid, "R1", "ready/valid after reset", {req_ready, rsp_valid}, 2'b10);
    idle_pins("R1");

    access(1, 16'h0010, 16'h1234, 2'b11, "R2", 0);
    access(0, 16'h0010, 16'h0000, 2'b11, "R7", 0);
    access(1, 16'h0010, 16'hCDEF, 2'b10, "R6", 0);
    access(0, 16'h0010, 16'h0000, 2'b11, "R6", 0);
    access(1, 16'h0010, 16'h0099, 2'b01, "R6", 0);
    access(0, 16'h0010, 16'h0000, 2'b11, "R6", 0);
    access(0, 16'h0010, 16'h0000, 2'b01, "R8", 0);
    access(0, 16'h0010, 16'h0000, 2'b10, "R8", 0);
    access(1, 16'h0010, 16'hFFFF, 2'b00, "R6", 0);
    access(0, 16'h0010, 16'h0000, 2'b11, "R6", 0);
    access(0, 16'h0010, 16'h0000, 2'b00, "R8", 0);
    access(1, 16'hFFFF, 16'h8001, 2'b11, "R3", 0);
    access(0, 16'hFFFF, 16'h0000, 2'b11, "R7", 0);
    // R11 ignored request during a busy write and a busy read
    access(1, 16'h0020, 16'h0F0F, 2'b11, "R11", 0);
    access(1, 16'h0021, 16'h7777, 2'b11, "R11", 0);
    access(1, 16'h0020, 16'h3C3C, 2'b11, "R11", 1);
    access(0, 16'h0020, 16'h0000, 2'b11, "R11", 1);
    access(0, 16'h0021, 16'h0000, 2'b11, "R11", 0);
    for (int i = 0; i < 6; i++)
      access(1, 16'h0100 + 16'(i), 16'h1111 * 16'(i + 1), 2'b11, "R5", 0);
    for (int i = 5; i >= 0; i--)
      access(0, 16'h0100 + 16'(i), 16'h0000, 2'b11, "R7", 0);

    // R13 reset in the middle of a read: no response may follow
    @(negedge clk);
    req_write = 1'b0; req_addr = 16'h0100; req_mask = 2'b11; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(req_ready && !rsp_valid, "R13", "ready after abort", {req_ready, rsp_valid}, 2'b10);
    idle_pins("R13");
    repeat (12) @(negedge clk);
    access(0, 16'h0102, 16'h0000, 2'b11, "R13", 0);

    repeat (4) @(negedge clk);
    chk(!contention, "R10", "bus contention seen", contention, 0);
    chk(exp_q.size() == 0, "R7", "responses outstanding", exp_q.size(), 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule